// File: doc/BRIEF.md
# Shared-Pin Address/Data Read Sequencer

This block runs read cycles on an external 16-bit bus where the address and the returned data travel over the same pins. A request carries an address. The block drives that address onto the shared pins and pulses an address latch enable so that an external latch can hold it. It then releases the pins and turns them around, and drops an active-low read strobe for a programmed number of clocks. The word that the device puts on the pins is captured at the moment the strobe rises. The block returns that word with a one-cycle done pulse.

Timing is counted in clocks of the peripheral clock that runs the block. Four settings shape the cycle: a 5-bit strobe length, a hold-cycle enable, a flash-mode enable that adds a fixed seven-clock extension, and the ALE polarity. The strobe length and the two enables are taken when a request is accepted. The polarity setting acts at once, so the idle level of ALE follows it too. The shared pins are modelled as a separate output, output-enable and input.

Top module: `shared_bus_reader`

## Requirements
- R1: While reset is held and when it is released, the block is idle: `rdN` is 1, `adOe` is 0, `busy` is 0, `done` is 0, and `aleOut` is at its inactive level (0 when `aleActLow` is 0).
- R2: A request sampled on a clock edge while idle makes ALE active for exactly the next 2 cycles. In those cycles `adOe` is 1 and `adOut` carries the request address.
- R3: In the cycle after ALE ends, the address stays driven (`adOe` 1). Then `adOe` is 0 for 1+F+H cycles before `rdN` falls. F is 7 when `flashEn` was 1 at acceptance and 0 otherwise. H is 1 when `holdEn` was 1 at acceptance and 0 otherwise.
- R4: `rdN` stays low for N consecutive cycles, where N is the `durField` value taken at acceptance and a value of 0 counts as 1.
- R5: On the edge where `rdN` rises, `rdData` takes the `adIn` value present in the last low cycle of `rdN`. It holds that value until the next read completes.
- R6: After `rdN` rises there are 1+H recovery cycles. `done` is 1 only in the last of them. `busy` is 1 from the cycle after acceptance through the `done` cycle and 0 in the cycle after it.
- R7: Requests that arrive while `busy` is 1, with any address, are ignored. The running read keeps its length and its address and returns its own data.
- R8: With `aleActLow` at 1, `aleOut` is inverted in every cycle: 0 while ALE is active and 1 otherwise.
- R9: `adOe` is never 1 while `rdN` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Read request, sampled on each edge while idle |
| reqAddr | input | 16 | Address for the request |
| durField | input | 5 | Read strobe length in clocks (0 means 1) |
| holdEn | input | 1 | Adds one hold clock to turnaround and recovery |
| flashEn | input | 1 | Adds a seven-clock extension to the turnaround |
| aleActLow | input | 1 | 1 selects active-low ALE |
| adIn | input | 16 | Value seen on the shared pins |
| adOut | output | 16 | Value driven on the shared pins |
| adOe | output | 1 | Output enable for the shared pins |
| aleOut | output | 1 | Address latch enable |
| rdN | output | 1 | Active-low read strobe |
| busy | output | 1 | Read in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Captured read data |

## Verification
Counting from the edge that accepts a request as cycle 0, the timeline is fixed. ALE covers cycles 0–1 and the address hold is cycle 2. The strobe covers cycles 3+T through 2+T+N, where T = 1+F+H. `done` falls in cycle 2+T+N+R, where R = 1+H, and `busy` drops in the cycle after that. The bench sweeps every strobe length together with every combination of hold, flash and polarity. It works out these cycle numbers arithmetically and compares every output at each falling clock edge against them. While the strobe is low, the bench feeds a data word that changes every cycle, so a capture one edge early or late shows up as a wrong value in `rdData`.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ALE,
    ST_AHOLD,
    ST_TURN,
    ST_READ,
    ST_RECOV
  } sbrState_t;

  typedef struct packed {
    logic aleOn;
    logic driveAddr;
    logic rdOn;
    logic loadAddr;
    logic capture;
  } sbrStrobe_t;

endpackage

// File: rtl/sbr_ctrl.sv
module sbr_ctrl
  import sbr_pkg::*;
#(
  parameter int DUR_W     = 5,
  parameter int FLASH_EXT = 7,
  parameter int ALE_LEN   = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [DUR_W-1:0] durField,
  input  logic             holdEn,
  input  logic             flashEn,
  output sbrStrobe_t       strobe,
  output logic             busy,
  output logic             done
);

  localparam int MAX_DUR = (1 << DUR_W);
  localparam int MAX_PH  = (MAX_DUR > FLASH_EXT + 2) ? MAX_DUR : FLASH_EXT + 2;
  localparam int CW      = $clog2(MAX_PH) + 1;

  sbrState_t        state;
  logic [CW-1:0]    cnt;
  logic [DUR_W-1:0] durR;
  logic             holdR;
  logic             flashR;
  logic             cntZero;

  assign cntZero = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      durR   <= '0;
      holdR  <= 1'b0;
      flashR <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state  <= ST_ALE;
            cnt    <= CW'(ALE_LEN - 1);
            durR   <= (durField == '0) ? DUR_W'(1) : durField;
            holdR  <= holdEn;
            flashR <= flashEn;
          end
        end
        ST_ALE: begin
          if (cntZero) state <= ST_AHOLD;
          else         cnt   <= cnt - 1'b1;
        end
        ST_AHOLD: begin
          state <= ST_TURN;
          cnt   <= (flashR ? CW'(FLASH_EXT) : '0) + CW'(holdR);
        end
        ST_TURN: begin
          if (cntZero) begin
            state <= ST_READ;
            cnt   <= CW'(durR) - 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_READ: begin
          if (cntZero) begin
            state <= ST_RECOV;
            cnt   <= CW'(holdR);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RECOV: begin
          if (cntZero) state <= ST_IDLE;
          else         cnt   <= cnt - 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.aleOn     = (state == ST_ALE);
    strobe.driveAddr = (state == ST_ALE) || (state == ST_AHOLD);
    strobe.rdOn      = (state == ST_READ);
    strobe.loadAddr  = (state == ST_IDLE) && reqValid;
    strobe.capture   = (state == ST_READ) && cntZero;
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_RECOV) && cntZero;

endmodule

// File: rtl/sbr_datapath.sv
module sbr_datapath
  import sbr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  sbrStrobe_t        strobe,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] adIn,
  input  logic              aleActLow,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              aleOut,
  output logic              rdN,
  output logic [DATA_W-1:0] rdData
);

  logic [DATA_W-1:0] addrR;
  logic [DATA_W-1:0] dataR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR <= '0;
      dataR <= '0;
    end else begin
      if (strobe.loadAddr) addrR <= reqAddr;
      if (strobe.capture)  dataR <= adIn;
    end
  end

  assign adOut  = strobe.driveAddr ? addrR : '0;
  assign adOe   = strobe.driveAddr;
  assign aleOut = strobe.aleOn ^ aleActLow;
  assign rdN    = ~strobe.rdOn;
  assign rdData = dataR;

endmodule

// File: rtl/shared_bus_reader.sv
module shared_bus_reader
  import sbr_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int DUR_W     = 5,
  parameter int FLASH_EXT = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [DATA_W-1:0] reqAddr,
  input  logic [DUR_W-1:0]  durField,
  input  logic              holdEn,
  input  logic              flashEn,
  input  logic              aleActLow,
  input  logic [DATA_W-1:0] adIn,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic              aleOut,
  output logic              rdN,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);

  sbrStrobe_t strobe;

  sbr_ctrl #(
    .DUR_W    (DUR_W),
    .FLASH_EXT(FLASH_EXT),
    .ALE_LEN  (2)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .durField(durField),
    .holdEn  (holdEn),
    .flashEn (flashEn),
    .strobe  (strobe),
    .busy    (busy),
    .done    (done)
  );

  sbr_datapath #(
    .DATA_W(DATA_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .reqAddr  (reqAddr),
    .adIn     (adIn),
    .aleActLow(aleActLow),
    .adOut    (adOut),
    .adOe     (adOe),
    .aleOut   (aleOut),
    .rdN      (rdN),
    .rdData   (rdData)
  );

endmodule

// File: rtl/sbr_checker.sv
module sbr_checker (
  input logic clk,
  input logic rstN,
  input logic aleOut,
  input logic aleActLow,
  input logic adOe,
  input logic rdN,
  input logic busy,
  input logic done
);

  logic aleAct;
  assign aleAct = aleOut ^ aleActLow;

  assert_no_drive_in_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe);

  assert_pins_released_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdN) |-> !$past(adOe));

  assert_ale_held_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(aleAct) |=> aleAct);

  assert_ale_two_cycles_R2: assert property (@(posedge clk) disable iff (!rstN)
    (aleAct && $past(aleAct)) |=> !aleAct);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_in_busy_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> busy);

  assert_busy_ends_after_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy);

  assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

bind shared_bus_reader sbr_checker u_sbr_checker (
  .clk      (clk),
  .rstN     (rstN),
  .aleOut   (aleOut),
  .aleActLow(aleActLow),
  .adOe     (adOe),
  .rdN      (rdN),
  .busy     (busy),
  .done     (done)
);

// File: tb/shared_bus_reader_bench.sv
`timescale 1ns/1ps
module shared_bus_reader_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [4:0]  durField = '0;
  logic        holdEn = 1'b0;
  logic        flashEn = 1'b0;
  logic        aleActLow = 1'b0;
  logic [15:0] adIn = 16'h0BAD;
  logic [15:0] adOut;
  logic        adOe, aleOut, rdN, busy, done;
  logic [15:0] rdData;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  shared_bus_reader u_shared_bus_reader (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .durField(durField), .holdEn(holdEn), .flashEn(flashEn),
    .aleActLow(aleActLow), .adIn(adIn), .adOut(adOut), .adOe(adOe),
    .aleOut(aleOut), .rdN(rdN), .busy(busy), .done(done), .rdData(rdData)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic runRead(input logic [15:0] addr, input int dur, input bit hd,
                         input bit fl, input bit pol, input bit spam);
    int t, n, r, total, rdStart, rdCnt;
    bit expAle, expOe, expRd;
    t = 1 + (fl ? 7 : 0) + (hd ? 1 : 0);
    n = (dur == 0) ? 1 : dur;
    r = 1 + (hd ? 1 : 0);
    rdStart = 3 + t;
    total = rdStart + n + r;
    rdCnt = 0;
    reqAddr   = addr;
    durField  = 5'(dur);
    holdEn    = hd;
    flashEn   = fl;
    aleActLow = pol;
    reqValid  = 1'b1;
    for (int k = 0; k <= total; k++) begin
      @(negedge clk);
      if (spam && k < total - 1) begin
        reqValid = 1'b1;
        reqAddr  = ~addr;
        durField = 5'(dur + 3);
        holdEn   = ~hd;
        flashEn  = ~fl;
      end else begin
        reqValid = 1'b0;
      end
      expAle = (k < 2);
      expOe  = (k < 3);
      expRd  = (k >= rdStart) && (k < rdStart + n);
      chk(aleOut == (expAle ^ pol), pol ? "R8" : "R2", aleOut, expAle ^ pol);
      chk(adOe == expOe, "R3", adOe, expOe);
      if (expOe) chk(adOut == addr, spam ? "R7" : "R2", adOut, addr);
      chk(rdN == !expRd, "R4", rdN, !expRd);
      chk(done == (k == total - 1), "R6", done, k == total - 1);
      chk(busy == (k < total), spam ? "R7" : "R6", busy, k < total);
      if (k >= total - 1)
        chk(rdData == 16'(addr + 16'(n - 1)), "R5", rdData, 16'(addr + 16'(n - 1)));
      if (!rdN) begin
        adIn = 16'(addr + 16'(rdCnt));
        rdCnt++;
      end else begin
        adIn = 16'h0BAD;
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held during reset
    chk(rdN == 1'b1 && adOe == 1'b0 && busy == 1'b0 && done == 1'b0 && aleOut == 1'b0,
        "R1", {busy, done, adOe, rdN, aleOut}, 5'b00010);
    rstN = 1'b1;
    @(negedge clk);
    chk(rdN == 1'b1 && adOe == 1'b0 && busy == 1'b0 && done == 1'b0 && aleOut == 1'b0,
        "R1", {busy, done, adOe, rdN, aleOut}, 5'b00010);
    // R8: idle level follows polarity
    aleActLow = 1'b1;
    @(negedge clk);
    chk(aleOut == 1'b1, "R8", aleOut, 1);
    aleActLow = 1'b0;
    for (int pol = 0; pol < 2; pol++)
      for (int fl = 0; fl < 2; fl++)
        for (int hd = 0; hd < 2; hd++)
          for (int dur = 0; dur < 32; dur++)
            runRead(16'(16'h1357 * (dur + 1) + 16'h0101 * (pol * 4 + fl * 2 + hd)),
                    dur, hd[0], fl[0], pol[0], (dur % 3) == 0);
    // R5: data held while idle after completion
    begin
      logic [15:0] held;
      held = rdData;
      repeat (4) @(negedge clk);
      chk(rdData == held, "R5", rdData, held);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule